// File: doc/BRIEF.md
# Dual-Resolution PWM Counter and Comparator

This block produces the raw pulse-width-modulated level for a switching stage. A free-running counter sweeps one PWM period, and the output stays high while the count is below the commanded pulse width. The period is 256 or 128 PWM clocks, chosen by the resolution input. An optional divide-by-two prescaler halves the rate at which the counter advances. This gives periods of 128, 256 or 512 input clocks. Dead-time insertion and output disabling belong to logic downstream. That logic uses the one-clock period-start pulse this block provides.

The pulse-width value, the resolution bit and the divide bit are plain level inputs with no handshake. The block has no back-pressure, because nothing is queued. A pulse-width change reaches the comparator in the same clock, in the middle of a period. The period in which the change happens therefore gets a duty between the old and new values. The end values map specially: 0 and 1 mean never high, and the all-ones code means always high. A change of resolution or divide setting restarts the period from count zero.

Top module: `pwm_cmp_core`

## Requirements
- R1: While `rst_n` is low, `pwm_raw` and `period_start` are 0. The first rising clock edge after release begins a period: the count is 0 and `period_start` is 1 for the following clock.
- R2: With `full_res`=1 a period lasts 256 PWM clocks; with `full_res`=0 it lasts 128. `period_start` is high for exactly one input clock per period, the first clock of count 0.
- R3: With `div2`=1 the count advances on every second input clock, so one PWM clock is two input clocks. With `div2`=0 it advances on every input clock.
- R4: `pwm_raw` is high while the count is below the pulse width, so it is high for PW PWM clocks per period. In 8-bit mode PW is `pw_value` (for 2..254). In 7-bit mode PW is `pw_value[6:0]` (for 2..126).
- R5: A pulse width of 0 or 1 keeps `pwm_raw` low for the whole period in both modes, except that in 7-bit mode a set bit 7 takes precedence (R6).
- R6: `pwm_raw` is high for the whole period when `full_res`=1 and `pw_value`=255. It is also high for the whole period when `full_res`=0 and either `pw_value[6:0]`=127 or `pw_value[7]`=1.
- R7: A new `pw_value` affects `pwm_raw` in the same clock it is applied, without waiting for a period boundary.
- R8: When `full_res` or `div2` differs from the setting in use at a clock edge, the new setting is taken up at that edge. The count restarts at 0, the prescaler phase restarts, and `period_start` is 1 in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_value | input | CNT_W (8) | Commanded pulse width |
| full_res | input | 1 | 1 selects the 8-bit period (256), 0 selects the 7-bit period (128) |
| div2 | input | 1 | 1 advances the counter every second clock |
| pwm_raw | output | 1 | Raw PWM level before dead-time and disabling |
| period_start | output | 1 | One-clock pulse at the start of each period |

## Verification
The embedded assertions check on every cycle the relations between pieces of the datapath:
- the short-mode count range;
- wrap to zero together with the start pulse;
- the counter holding between prescaler ticks, and ticks alternating when dividing;
- the fixed-low and fixed-high pulse-width codes;
- restart on a setting change.

Only the bench scenarios can show whole-period behaviour. These cover the high time of a period for a given pulse width, the spacing of start pulses in each mode and divide setting, and the blended duty of a period in which the pulse width changes part-way.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int unsigned PWMC_DEF_CNT_W = 8;

  typedef struct packed {
    logic full_res;
    logic div2;
  } pwmc_cfg_t;

  localparam pwmc_cfg_t PWMC_CFG_RST = '{full_res: 1'b1, div2: 1'b0};
endpackage

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en,
  input  logic restart,
  output logic tick
);
  logic phase_q;

  // Phase resets to 1 so the first edge after reset is an advance edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b1;
    else if (restart) phase_q <= 1'b0;
    else if (div_en)  phase_q <= ~phase_q;
  end

  assign tick = div_en ? phase_q : 1'b1;

  // R3: when dividing, an advance tick is followed by an idle clock
  a_r3_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && tick && !restart) |=> !tick);
endmodule

// File: rtl/pwmc_counter.sv
module pwmc_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             full_res,
  output logic [CNT_W-1:0] cnt,
  output logic             period_start
);
  localparam logic [CNT_W-1:0] TOP_FULL  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TOP_SHORT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] top;
  logic             at_top;

  assign top    = full_res ? TOP_FULL : TOP_SHORT;
  assign at_top = (cnt >= top);

  // Count resets to all ones so the first advance wraps into a fresh period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= TOP_FULL;
      period_start <= 1'b0;
    end else begin
      period_start <= restart | (tick & at_top);
      if (restart)   cnt <= '0;
      else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
    end
  end

  // R2: in short mode the count never reaches the upper half
  a_r2_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_res) |-> (cnt[CNT_W-1] == 1'b0));
  // R2: an advance at the top value wraps to zero and flags the period start
  a_r2_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_top && !restart) |=> (cnt == '0 && period_start));
  // R3: without an advance tick the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));
  // R2: start pulse lasts a single clock
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
endmodule

// File: rtl/pwmc_threshold.sv
module pwmc_threshold #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] pw,
  input  logic             full_res,
  output logic [CNT_W:0]   thr
);
  localparam int unsigned SW = CNT_W - 1;
  localparam logic [CNT_W:0] FULL_ON  = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] SHORT_ON = {2'b01, {SW{1'b0}}};

  logic [SW-1:0] pw_lo;
  assign pw_lo = pw[SW-1:0];

  always_comb begin
    if (full_res) begin
      if (pw <= 1)  thr = '0;
      else if (&pw) thr = FULL_ON;
      else          thr = {1'b0, pw};
    end else begin
      if (pw[CNT_W-1] || (&pw_lo)) thr = SHORT_ON;
      else if (pw_lo <= 1)         thr = '0;
      else                         thr = {2'b00, pw_lo};
    end
  end
endmodule

// File: rtl/pwm_cmp_core.sv
module pwm_cmp_core
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W = PWMC_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pw_value,
  input  logic             full_res,
  input  logic             div2,
  output logic             pwm_raw,
  output logic             period_start
);
  localparam int unsigned SW = CNT_W - 1;

  pwmc_cfg_t        cfg_q;
  pwmc_cfg_t        cfg_in;
  logic             restart;
  logic             run_q;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   thr;

  assign cfg_in  = '{full_res: full_res, div2: div2};
  assign restart = (cfg_in != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= PWMC_CFG_RST;
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_in;
      run_q <= 1'b1;
    end
  end

  pwmc_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_en  (cfg_q.div2),
    .restart (restart),
    .tick    (tick)
  );

  pwmc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .restart      (restart),
    .full_res     (cfg_q.full_res),
    .cnt          (cnt),
    .period_start (period_start)
  );

  pwmc_threshold #(.CNT_W(CNT_W)) u_thr (
    .pw       (pw_value),
    .full_res (cfg_q.full_res),
    .thr      (thr)
  );

  // Unregistered compare: a new pulse width acts in the same clock.
  assign pwm_raw = run_q && ({1'b0, cnt} < thr);

  logic pw_never, pw_always;
  assign pw_never  = (pw_value <= 1) && (cfg_q.full_res || !pw_value[CNT_W-1]);
  assign pw_always = cfg_q.full_res ? (&pw_value)
                                    : (pw_value[CNT_W-1] || (&pw_value[SW-1:0]));

  // R1: nothing is driven before the first edge after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q) |-> (!pwm_raw && !period_start));
  // R5: codes 0 and 1 never drive the output high
  a_r5_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    pw_never |-> !pwm_raw);
  // R6: all-ones codes hold the output high once running
  a_r6_always_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pw_always) |-> pwm_raw);
  // R8: a setting change restarts the period
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && period_start));
endmodule

// File: tb/pwm_cmp_core_tb_top.sv
`timescale 1ns/1ps
module pwm_cmp_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pw_value = 8'd0;
  logic       full_res = 1'b1;
  logic       div2 = 1'b0;
  logic       pwm_raw, period_start;

  always #2.5 clk = ~clk;

  pwm_cmp_core dut_i (
    .clk(clk), .rst_n(rst_n), .pw_value(pw_value), .full_res(full_res),
    .div2(div2), .pwm_raw(pwm_raw), .period_start(period_start)
  );

  typedef struct {
    logic  pwm;
    logic  st;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference state built from the requirements
  int unsigned m_cnt = 255;
  bit m_ph = 1'b1, m_res = 1'b1, m_div = 1'b0, m_run = 1'b0, m_st = 1'b0;

  function automatic int unsigned ref_thr(logic [7:0] pw, bit res);
    if (res) begin
      if (pw == 8'd255) return 256;
      if (pw < 8'd2) return 0;
      return pw;
    end
    if (pw[7] || pw[6:0] == 7'd127) return 128;
    if (pw[6:0] < 7'd2) return 0;
    return pw[6:0];
  endfunction

  task automatic model_edge();
    int unsigned top;
    bit adv;
    if (!rst_n) begin
      m_cnt = 255; m_ph = 1'b1; m_res = 1'b1; m_div = 1'b0; m_run = 1'b0; m_st = 1'b0;
      return;
    end
    m_run = 1'b1;
    if (full_res != m_res || div2 != m_div) begin      // R8
      m_res = full_res; m_div = div2; m_cnt = 0; m_ph = 1'b0; m_st = 1'b1;
      return;
    end
    top = m_res ? 255 : 127;                           // R2
    adv = m_div ? m_ph : 1'b1;                         // R3
    if (m_div) m_ph = ~m_ph;
    m_st = 1'b0;
    if (adv) begin
      if (m_cnt >= top) begin m_cnt = 0; m_st = 1'b1; end
      else m_cnt = m_cnt + 1;
    end
  endtask

  // Driver: after each edge, advance the reference, apply inputs, queue expectation
  task automatic drive(input logic [7:0] pw, input bit res, input bit dv,
                       input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      model_edge();
      pw_value = pw; full_res = res; div2 = dv;
      exp_q.push_back('{pwm: (m_run && m_cnt < ref_thr(pw, m_res)), st: m_st, tag: tag});
    end
  endtask

  // Monitor: compare away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (pwm_raw !== e.pwm || period_start !== e.st) begin
          n_fail++;
          $display("FAIL %s: pwm_raw=%0b period_start=%0b expected pwm_raw=%0b period_start=%0b at %0t",
                   e.tag, pwm_raw, period_start, e.pwm, e.st, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    drive(8'd64, 1'b1, 1'b0, 4, "R1 reset state");
    rst_n = 1'b1;
    drive(8'd64, 1'b1, 1'b0, 300, "R1 R2 R4 8-bit pw=64");
    drive(8'd0, 1'b1, 1'b0, 260, "R5 pw=0 8-bit");
    drive(8'd1, 1'b1, 1'b0, 260, "R5 pw=1 8-bit");
    drive(8'd255, 1'b1, 1'b0, 260, "R6 pw=255 8-bit");
    drive(8'd254, 1'b1, 1'b0, 260, "R4 pw=254 8-bit");
    drive(8'd50, 1'b1, 1'b0, 100, "R7 before change");
    drive(8'd200, 1'b1, 1'b0, 200, "R7 raise mid-period");
    drive(8'd180, 1'b1, 1'b0, 130, "R7 before drop");
    drive(8'd30, 1'b1, 1'b0, 200, "R7 drop mid-period");
    drive(8'd40, 1'b0, 1'b0, 300, "R8 R2 R4 7-bit pw=40");
    drive(8'd127, 1'b0, 1'b0, 140, "R6 pw=127 7-bit");
    drive(8'h85, 1'b0, 1'b0, 140, "R6 bit7 set 7-bit");
    drive(8'd1, 1'b0, 1'b0, 140, "R5 pw=1 7-bit");
    drive(8'd126, 1'b0, 1'b0, 140, "R4 pw=126 7-bit");
    drive(8'd100, 1'b1, 1'b1, 600, "R8 R3 div2 8-bit pw=100");
    drive(8'd90, 1'b0, 1'b1, 300, "R8 R3 div2 7-bit pw=90");
    drive(8'd20, 1'b0, 1'b1, 100, "R7 div2 before change");
    drive(8'd110, 1'b0, 1'b1, 200, "R7 div2 after change");
    drive(8'd128, 1'b1, 1'b0, 300, "R8 back to 8-bit pw=128");
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule